// File: doc/BRIEF.md
# Level-Tracking Interrupt Pending Tracker

This block holds one pending bit for each of eight interrupt sources and presents the most urgent enabled one to a single hart. Each source input is first synchronized. It is then rectified according to the mode programmed for that source, and the result sets or clears the pending bit. The block drives one interrupt line toward the hart. Software programs it through a small register port: a global delivery bit, an enable mask, the pending bits, and one configuration word per source that holds the mode and the priority.

When the hart reads the claim register, it receives the number of the winning source, and that source's pending bit clears in the same cycle. In the two level modes the pending bit follows the rectified input in both directions. A source that stops requesting therefore drops out without a claim. A source that is still requesting after a claim returns on the following cycle. In the two edge modes the pending bit is latched by a qualifying edge and stays set until a claim or a software write clears it.

Top module: `irq_pend_ctrl`

## Requirements
- R1: The configuration word of source i sits at address 16+i. Bits [2:0] hold the mode and bits [6:4] hold the priority, and both read back exactly as written. Mode code 0 means inactive, 4 rising edge, 5 falling edge, 6 active-high level and 7 active-low level. Codes 1, 2 and 3 behave as inactive.
- R2: Each source input passes through two flip-flops before rectification. An input level present at clock edge k changes a level-mode pending bit at edge k+2.
- R3: In active-high level mode the pending bit is set while the synchronized input is 1 and is cleared while it is 0, with no claim needed.
- R4: In active-low level mode the pending bit follows the inverted synchronized input in both directions.
- R5: In rising-edge mode a 0-to-1 transition of the synchronized input sets pending. In falling-edge mode a 1-to-0 transition sets it. Once set, the bit holds after the input returns to its former level.
- R6: A source in an inactive mode never becomes pending, and writes to its pending bit have no effect.
- R7: A read of address 1 (claim) returns, one cycle later in bits [7:0], the winning source number (source index plus one). It also clears that source's pending bit. In a level mode the bit is set again on the cycle after the claim if the rectified input is still high.
- R8: A claim read with no source both pending and enabled returns 0 and leaves every pending bit unchanged.
- R9: A source is eligible only when it is pending and its bit in the enable mask (address 2) is 1. Among eligible sources, priority value 1 wins over larger values, and a priority of 0 counts as 1. Equal priorities go to the lowest source index.
- R10: irq_o is 1 exactly while some source is pending and enabled and bit 0 of address 0 (global delivery) is 1. It follows a pending change in the same cycle the pending bit changes.
- R11: Address 3 reads the pending bits. A write to it loads bit i into the pending bit of each edge-mode source i. Within a cycle, a software write overrides a new edge, and a new edge overrides a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt source inputs |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a claim when the address is 1) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, held until the next read |
| irq_o | output | 1 | Interrupt request to the hart |

## Verification
Directed patterns give a level source held high and then dropped, which separates level tracking in both directions from the latch-until-claim behaviour. A single-cycle pulse on an edge source shows that the edge modes hold pending after the input falls back. Sources with tied priorities (one at priority 0) and one masked source are claimed in turn, which exposes any error in ordering, in the 0-as-1 rule or in the enable gating. A long run of random inputs, modes, writes and claims is compared every cycle against a behavioural model, which catches mistakes in precedence and latency that the directed cases do not reach.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   localparam int REG_CTRL     = 0;
   localparam int REG_CLAIM    = 1;
   localparam int REG_ENABLE   = 2;
   localparam int REG_PEND     = 3;
   localparam int CFG_BASE     = 16;
   localparam int MODE_W       = 3;
   localparam int CFG_PRIO_LSB = 4;

   typedef struct packed {
      logic is_edge;
      logic is_level;
      logic inv;
   } src_kind_t;

   function automatic src_kind_t decode_mode(input logic [MODE_W-1:0] m);
      src_kind_t k;
      k = '0;
      case (m)
         3'd4: begin k.is_edge  = 1'b1; k.inv = 1'b0; end
         3'd5: begin k.is_edge  = 1'b1; k.inv = 1'b1; end
         3'd6: begin k.is_level = 1'b1; k.inv = 1'b0; end
         3'd7: begin k.is_level = 1'b1; k.inv = 1'b1; end
         default: k = '0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/irq_src_front.sv
module irq_src_front #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_i,
   input  logic [N-1:0] inv_i,
   output logic [N-1:0] rect_o,
   output logic [N-1:0] rise_o
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_src_front: STAGES must be at least 2");
      end
   endgenerate

   logic [N-1:0] stage_q [STAGES];
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= raw_i;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
         prev_q <= stage_q[LAST];
      end
   end

   // rectified level and the rising edge of the rectified level
   assign rect_o = stage_q[LAST] ^ inv_i;
   assign rise_o = rect_o & ~(prev_q ^ inv_i);

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] is_edge_i,
   input  logic [N-1:0] is_level_i,
   input  logic [N-1:0] rect_i,
   input  logic [N-1:0] rise_i,
   input  logic [N-1:0] claim_i,
   input  logic         sw_we_i,
   input  logic [N-1:0] sw_val_i,
   output logic [N-1:0] pend_o
);

   logic [N-1:0] pend_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_cell
         logic nxt;

         always_comb begin
            nxt = 1'b0;
            if (is_level_i[i]) begin
               nxt = claim_i[i] ? 1'b0 : rect_i[i];
            end else if (is_edge_i[i]) begin
               if (sw_we_i)         nxt = sw_val_i[i];
               else if (rise_i[i])  nxt = 1'b1;
               else if (claim_i[i]) nxt = 1'b0;
               else                 nxt = pend_q[i];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= nxt;
         end

         // level tracking in both directions; covers R4 as well
         assert_level_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (is_level_i[i] && !claim_i[i]) |=> (pend_q[i] == $past(rect_i[i])));

         assert_inactive_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level_i[i] && !is_edge_i[i]) |=> !pend_q[i]);

         assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (is_level_i[i] && claim_i[i]) |=> !pend_q[i]);

         assert_edge_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (is_edge_i[i] && pend_q[i] && !claim_i[i] && !sw_we_i) |=> pend_q[i]);
      end
   endgenerate

   assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N      = 8,
   parameter int PRIO_W = 3,
   parameter int ID_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N-1:0]           elig_i,
   input  logic [N-1:0][PRIO_W-1:0] prio_i,
   output logic [N-1:0]           win_oh_o,
   output logic [ID_W-1:0]        win_num_o,
   output logic                   any_o
);

   logic [PRIO_W-1:0] best_p;
   logic [PRIO_W-1:0] eff_p;
   logic              found;

   always_comb begin
      best_p    = '0;
      eff_p     = '0;
      found     = 1'b0;
      win_oh_o  = '0;
      win_num_o = '0;
      for (int i = 0; i < N; i++) begin
         eff_p = (prio_i[i] == '0) ? PRIO_W'(1) : prio_i[i];
         if (elig_i[i] && (!found || eff_p < best_p)) begin
            found     = 1'b1;
            best_p    = eff_p;
            win_oh_o  = '0;
            win_oh_o[i] = 1'b1;
            win_num_o = ID_W'(i + 1);
         end
      end
   end

   assign any_o = found;

   assert_one_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_oh_o));

   assert_winner_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_oh_o & ~elig_i) == '0));

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
   parameter int N_SRC       = 8,
   parameter int PRIO_W      = 3,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   import irq_pend_pkg::*;

   localparam int ID_W = $clog2(N_SRC + 1);

   generate
      if (N_SRC > DATA_W) begin : g_bad_nsrc
         $error("irq_pend_ctrl: N_SRC exceeds DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("irq_pend_ctrl: DATA_W must be at least 8");
      end
      if (CFG_PRIO_LSB + PRIO_W > DATA_W) begin : g_bad_prio
         $error("irq_pend_ctrl: priority field does not fit");
      end
      if (CFG_BASE + N_SRC > (1 << ADDR_W)) begin : g_bad_addr
         $error("irq_pend_ctrl: address space too small");
      end
   endgenerate

   logic                            glb_q;
   logic [N_SRC-1:0]                en_q;
   logic [N_SRC-1:0][MODE_W-1:0]    mode_q;
   logic [N_SRC-1:0][PRIO_W-1:0]    prio_q;
   logic [N_SRC-1:0]                is_edge, is_level, inv;
   logic [N_SRC-1:0]                rect, rise, pend, elig, win_oh, claim_oh;
   logic [ID_W-1:0]                 win_num;
   logic                            any_elig;
   logic                            claim_rd, pend_we;
   logic [DATA_W-1:0]               rd_val;

   assign claim_rd = bus_re && (bus_addr == ADDR_W'(REG_CLAIM));
   assign pend_we  = bus_we && (bus_addr == ADDR_W'(REG_PEND));

   // global and enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= 1'b0;
         en_q  <= '0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(REG_CTRL))   glb_q <= bus_wdata[0];
         if (bus_addr == ADDR_W'(REG_ENABLE)) en_q  <= bus_wdata[N_SRC-1:0];
      end
   end

   // per-source configuration words and mode decode
   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
         src_kind_t kind;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_q[i] <= '0;
               prio_q[i] <= '0;
            end else if (bus_we && bus_addr == ADDR_W'(CFG_BASE + i)) begin
               mode_q[i] <= bus_wdata[MODE_W-1:0];
               prio_q[i] <= bus_wdata[CFG_PRIO_LSB +: PRIO_W];
            end
         end

         assign kind        = decode_mode(mode_q[i]);
         assign is_edge[i]  = kind.is_edge;
         assign is_level[i] = kind.is_level;
         assign inv[i]      = kind.inv;
      end
   endgenerate

   irq_src_front #(
      .N      (N_SRC),
      .STAGES (SYNC_STAGES)
   ) u_front (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (src_i),
      .inv_i  (inv),
      .rect_o (rect),
      .rise_o (rise)
   );

   assign claim_oh = win_oh & {N_SRC{claim_rd}};

   irq_pend_bank #(
      .N (N_SRC)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_edge_i  (is_edge),
      .is_level_i (is_level),
      .rect_i     (rect),
      .rise_i     (rise),
      .claim_i    (claim_oh),
      .sw_we_i    (pend_we),
      .sw_val_i   (bus_wdata[N_SRC-1:0]),
      .pend_o     (pend)
   );

   assign elig = pend & en_q;

   irq_prio_pick #(
      .N      (N_SRC),
      .PRIO_W (PRIO_W),
      .ID_W   (ID_W)
   ) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig_i    (elig),
      .prio_i    (prio_q),
      .win_oh_o  (win_oh),
      .win_num_o (win_num),
      .any_o     (any_elig)
   );

   // read mux
   always_comb begin
      rd_val = '0;
      if (bus_addr == ADDR_W'(REG_CTRL))        rd_val[0] = glb_q;
      else if (bus_addr == ADDR_W'(REG_CLAIM))  rd_val[ID_W-1:0] = win_num;
      else if (bus_addr == ADDR_W'(REG_ENABLE)) rd_val[N_SRC-1:0] = en_q;
      else if (bus_addr == ADDR_W'(REG_PEND))   rd_val[N_SRC-1:0] = pend;
      else begin
         for (int i = 0; i < N_SRC; i++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + i)) begin
               rd_val[MODE_W-1:0]             = mode_q[i];
               rd_val[CFG_PRIO_LSB +: PRIO_W] = prio_q[i];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_val;
   end

   assign irq_o = glb_q && (|elig);

   assert_empty_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && !any_elig) |=> (bus_rdata == '0));

   assert_empty_claim_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && !any_elig && !pend_we && ((is_level | ~is_edge) == '0)) |=> $stable(pend));

   assert_claim_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && any_elig) |=> (bus_rdata != '0));

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (glb_q && any_elig));

endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src = '0;
   logic       bus_we = 1'b0, bus_re = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_o;

   int total = 0;
   int bad = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   irq_pend_ctrl u_irq_pend_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // behavioural reference model
   bit [7:0] m_s1, m_s2, m_prev, m_pend, m_en, m_rdata;
   bit       m_glb;
   int       m_mode [8];
   int       m_prio [8];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_en = 0; m_rdata = 0; m_glb = 0;
         for (int i = 0; i < 8; i++) begin m_mode[i] = 0; m_prio[i] = 0; end
      end else begin
         int best, bp, p;
         bit claim, rect, ev;
         bit [7:0] np;
         best = -1; bp = 99;
         for (int i = 0; i < 8; i++) begin
            if (m_pend[i] && m_en[i]) begin
               p = (m_prio[i] == 0) ? 1 : m_prio[i];
               if (p < bp) begin bp = p; best = i; end
            end
         end
         claim = bus_re && bus_addr == 1;
         if (bus_re) begin
            if (bus_addr == 0) m_rdata = {7'd0, m_glb};
            else if (bus_addr == 1) m_rdata = 8'(best + 1);
            else if (bus_addr == 2) m_rdata = m_en;
            else if (bus_addr == 3) m_rdata = m_pend;
            else if (bus_addr >= 16 && bus_addr < 24)
               m_rdata = 8'((m_prio[bus_addr-16] << 4) | m_mode[bus_addr-16]);
            else m_rdata = 0;
         end
         for (int i = 0; i < 8; i++) begin
            np[i] = 0;
            if (m_mode[i] == 6 || m_mode[i] == 7) begin
               rect = (m_mode[i] == 6) ? m_s2[i] : !m_s2[i];
               np[i] = (claim && best == i) ? 1'b0 : rect;
            end else if (m_mode[i] == 4 || m_mode[i] == 5) begin
               ev = (m_mode[i] == 4) ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
               if (bus_we && bus_addr == 3) np[i] = bus_wdata[i];
               else if (ev) np[i] = 1;
               else if (claim && best == i) np[i] = 0;
               else np[i] = m_pend[i];
            end
         end
         m_pend = np;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
         if (bus_we) begin
            if (bus_addr == 0) m_glb = bus_wdata[0];
            if (bus_addr == 2) m_en = bus_wdata;
            if (bus_addr >= 16 && bus_addr < 24) begin
               m_mode[bus_addr-16] = bus_wdata[2:0];
               m_prio[bus_addr-16] = bus_wdata[6:4];
            end
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (irq_o !== (m_glb && |(m_pend & m_en))) begin
            bad++;
            $display("FAIL %s model irq actual=%0d expected=%0d t=%0t", cur_req, irq_o,
                     (m_glb && |(m_pend & m_en)), $time);
         end
         total++;
         if (bus_rdata !== m_rdata) begin
            bad++;
            $display("FAIL %s model rdata actual=%0h expected=%0h t=%0t", cur_req, bus_rdata,
                     m_rdata, $time);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_we = 1; bus_addr = 5'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd(input int a);
      @(negedge clk);
      bus_re = 1; bus_addr = 5'(a);
      @(negedge clk);
      bus_re = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   bit done = 0;

   initial begin
      #(200000 * 8);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R10";
      check("R10", irq_o, 0, "irq after reset");
      check("R1", bus_rdata, 0, "rdata after reset");

      cur_req = "R1";
      wr(16, 8'h26); rd(16);
      check("R1", bus_rdata, 8'h26, "cfg0 readback");
      wr(23, 8'h03); rd(23);
      check("R1", bus_rdata, 8'h03, "cfg7 readback");
      src[7] = 1; idle(4); rd(3);
      check("R1", bus_rdata, 0, "mode 3 acts inactive");
      wr(0, 1); wr(2, 8'hFF);

      cur_req = "R2";
      src[0] = 1; idle(2);
      check("R2", irq_o, 0, "irq before sync latency");
      idle(1);
      check("R2", irq_o, 1, "irq after sync latency");
      cur_req = "R3";
      src[0] = 0; idle(3);
      check("R3", irq_o, 0, "level high cleared by input");

      cur_req = "R7";
      src[0] = 1; idle(3); rd(1);
      check("R7", bus_rdata, 1, "claim level source");
      check("R7", irq_o, 0, "pending cleared by claim");
      idle(1);
      check("R7", irq_o, 1, "level source re-pends");
      src[0] = 0; idle(3);

      cur_req = "R4";
      src[1] = 1; wr(17, 8'h37); idle(3); rd(3);
      check("R4", bus_rdata, 0, "level low idle");
      src[1] = 0; idle(3); rd(3);
      check("R4", bus_rdata, 8'h02, "level low asserted");
      src[1] = 1; idle(3); rd(3);
      check("R4", bus_rdata, 0, "level low released");

      cur_req = "R5";
      wr(18, 8'h04);
      src[2] = 1; idle(1); src[2] = 0; idle(4); rd(3);
      check("R5", bus_rdata, 8'h04, "rising pulse latched");
      rd(1);
      check("R7", bus_rdata, 3, "claim edge source");
      rd(3);
      check("R5", bus_rdata, 0, "edge cleared by claim");
      src[3] = 1; wr(19, 8'h15); idle(3);
      src[3] = 0; idle(4); rd(3);
      check("R5", bus_rdata, 8'h08, "falling edge latched");

      cur_req = "R11";
      wr(3, 8'h00); rd(3);
      check("R11", bus_rdata, 0, "pending write clears");
      wr(3, 8'h08); rd(3);
      check("R11", bus_rdata, 8'h08, "pending write sets");
      wr(3, 8'h00);

      cur_req = "R6";
      src[4] = 1; idle(4); wr(3, 8'h10); rd(3);
      check("R6", bus_rdata, 0, "inactive pending write ignored");

      cur_req = "R8";
      rd(1);
      check("R8", bus_rdata, 0, "empty claim");
      rd(3);
      check("R8", bus_rdata, 0, "empty claim no change");

      cur_req = "R9";
      wr(21, 8'h14);
      src[0] = 1; src[2] = 1; src[5] = 1; idle(4);
      rd(1);
      check("R9", bus_rdata, 3, "tie prio0 vs prio1 lowest index");
      rd(1);
      check("R9", bus_rdata, 6, "next priority");
      rd(1);
      check("R9", bus_rdata, 1, "lowest priority last");
      wr(2, 8'hFE);
      check("R10", irq_o, 0, "masked source no irq");
      rd(1);
      check("R9", bus_rdata, 0, "masked source not claimed");
      cur_req = "R10";
      wr(2, 8'hFF);
      check("R10", irq_o, 1, "unmask raises irq");
      wr(0, 0);
      check("R10", irq_o, 0, "global off");
      wr(0, 1);
      check("R10", irq_o, 1, "global on");

      cur_req = "R11";
      repeat (3000) begin
         int r, a;
         @(negedge clk);
         src = 8'($urandom);
         r = int'($urandom % 8);
         a = int'($urandom % 10);
         if (a <= 3) bus_addr = 5'(a);
         else if (a == 9) bus_addr = 5'd5;
         else bus_addr = 5'(16 + ($urandom % 8));
         bus_wdata = 8'($urandom);
         bus_we = (r == 0 || r == 1);
         bus_re = (r == 2 || r == 3);
      end
      @(negedge clk);
      bus_we = 0; bus_re = 0;
      idle(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule